// File: doc/BRIEF.md
# GPIO Interrupt Detector

This block watches a bank of general-purpose input lines (eight by default) and turns their activity into per-line interrupt status and one combined interrupt request. The pin levels it receives are already synchronized to its clock. Software sets each line up through byte-wide registers on a simple memory-mapped bus. A line can sense a level (high or low) or an edge (rising, falling, or both).

Edge events are caught by comparing each pin with its value one clock earlier. An event sets a sticky status bit, and software releases that bit with a write-one-to-clear. Level status is not stored: it tracks the pin directly, so it drops as soon as the pin leaves the active level. The raw status and the status after the per-line enable are read at separate addresses. The interrupt output is high whenever any enabled line has status.

Top module: `gpio_irq_detect`

## Requirements
- R1: After reset, all configuration registers, all edge status bits and `irq_o` are zero.
- R2: Reads are combinational from `bus_addr`: 0x404 returns the mode register, 0x408 the any-edge register, 0x40C the polarity register, 0x410 the enable register, 0x414 the raw status and 0x418 the masked status. Every other address, including 0x41C, reads zero. A write to 0x404, 0x408, 0x40C or 0x410 takes effect at the next clock edge.
- R3: When a line's mode bit is 1 (level), its raw status bit equals 1 exactly while the pin equals that line's polarity bit (1 = active high, 0 = active low). It follows the pin in the same cycle and needs no clear.
- R4: When a line's mode bit is 0 and its any-edge bit is 0, polarity 1 detects a rising edge and polarity 0 a falling edge. An edge is a pin value that differs from the value one clock earlier, and the raw bit is set at the clock edge that samples the new value.
- R5: An edge status bit stays set after the pin returns and remains set until it is cleared.
- R6: When a line is in edge mode and its any-edge bit is 1, both rising and falling edges set the status, whatever the polarity bit holds.
- R7: Writing to 0x41C clears the edge status of each line whose data bit is 1. Lines whose bit is 0 keep their status. The write does not change the status of lines in level mode.
- R8: If a clear write and a new detected edge on the same line fall in the same cycle, the status bit is set afterwards.
- R9: Masked status is raw status AND the enable register. `irq_o` is the OR of the masked status bits.
- R10: Writes to 0x414, 0x418 or any unmapped address change no register.
- R11: While a line is in level mode its edge status is held clear, so returning the line to edge mode starts with no pending event.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 12 | Byte offset for the read or write |
| bus_wr | input | 1 | Write strobe for the current cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for `bus_addr` |
| pin_i | input | 8 | Synchronized pin levels |
| irq_o | output | 1 | Combined interrupt request |

## Verification
The assertions check on every cycle that an edge status bit is sticky and that a clear without a coincident edge empties the bit (R5, R7). They also check that a coincident edge beats the clear (R8), that level mode keeps the edge store empty (R11), and that the interrupt can only be raised while some line is enabled (R9). The bench's scenarios are needed to show that detection follows the configured polarity and any-edge selection, that level status follows the pin without a clear, that writes to read-only addresses are ignored, and that each address decodes to the right register. A long random run against a behavioural model then mixes all of these.

// File: rtl/gpio_irq_pkg.sv
// Package: register offsets shared by the interrupt detector and its bench.
package gpio_irq_pkg;
    localparam logic [11:0] OFS_MODE   = 12'h404;
    localparam logic [11:0] OFS_ANYEDG = 12'h408;
    localparam logic [11:0] OFS_POL    = 12'h40C;
    localparam logic [11:0] OFS_ENA    = 12'h410;
    localparam logic [11:0] OFS_RAW    = 12'h414;
    localparam logic [11:0] OFS_MSK    = 12'h418;
    localparam logic [11:0] OFS_CLR    = 12'h41C;
endpackage

// File: rtl/gpio_irq_cfg.sv
// Module: gpio_irq_cfg
// Holds the four writable configuration registers and decodes the clear
// strobe. Assumes single-cycle writes. Writes to any other address are
// ignored. The clear strobe is combinational and lasts one cycle.
module gpio_irq_cfg
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] mode_q,
    output logic [NUM_PINS-1:0] anyedg_q,
    output logic [NUM_PINS-1:0] pol_q,
    output logic [NUM_PINS-1:0] ena_q,
    output logic [NUM_PINS-1:0] clr_pulse
);
    // Purpose: register writes into the configuration set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q   <= '0;
            anyedg_q <= '0;
            pol_q    <= '0;
            ena_q    <= '0;
        end else if (bus_wr) begin
            if (bus_addr == ADDR_W'(OFS_MODE))   mode_q   <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_ANYEDG)) anyedg_q <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_POL))    pol_q    <= bus_wdata;
            if (bus_addr == ADDR_W'(OFS_ENA))    ena_q    <= bus_wdata;
        end
    end

    // Purpose: a one-cycle clear mask while a clear write is on the bus.
    always_comb begin
        clr_pulse = '0;
        if (bus_wr && bus_addr == ADDR_W'(OFS_CLR)) clr_pulse = bus_wdata;
    end

    // R10: a write to the raw-status address leaves the config unchanged
    a_r10_ro_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && bus_addr == ADDR_W'(OFS_RAW)) |=>
            (mode_q == $past(mode_q) && ena_q == $past(ena_q)));
endmodule

// File: rtl/gpio_irq_lane.sv
// Module: gpio_irq_lane
// Detection for one line. Assumes pin_i is already synchronized. Keeps the
// previous pin value for edge finding and a sticky edge flag. In level
// mode the status follows the pin and the edge flag is held clear.
module gpio_irq_lane (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic mode_i,
    input  logic anyedg_i,
    input  logic pol_i,
    input  logic clr_i,
    output logic raw_o
);
    logic prev_q;
    logic flag_q;
    logic rise;
    logic fall;
    logic edge_hit;

    // Purpose: remember the pin value of the previous cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= 1'b0;
        else        prev_q <= pin_i;
    end

    // Purpose: choose which transitions count for this line.
    always_comb begin
        rise     = pin_i & ~prev_q;
        fall     = ~pin_i & prev_q;
        edge_hit = anyedg_i ? (rise | fall) : (pol_i ? rise : fall);
    end

    // Purpose: sticky edge flag, cleared by a clear write, and a new edge wins.
    always_ff @(posedge clk) begin
        if (!rst_n)      flag_q <= 1'b0;
        else if (mode_i) flag_q <= 1'b0;
        else             flag_q <= edge_hit | (flag_q & ~clr_i);
    end

    // Purpose: raw status is either the level match or the edge flag.
    always_comb raw_o = mode_i ? ~(pin_i ^ pol_i) : flag_q;

    // R5: the flag stays set when no clear arrives
    a_r5_edge_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && flag_q && !clr_i) |=> flag_q);
    // R7: a clear with no coincident edge empties the flag
    a_r7_clear_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && clr_i && !edge_hit) |=> !flag_q);
    // R8: an edge in the same cycle as a clear leaves the flag set
    a_r8_edge_beats_clear: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode_i && edge_hit) |=> flag_q);
    // R11: level mode keeps the edge flag empty
    a_r11_level_holds_clear: assert property (@(posedge clk) disable iff (!rst_n)
        mode_i |=> !flag_q);
endmodule

// File: rtl/gpio_irq_rdmux.sv
// Module: gpio_irq_rdmux
// Combinational read decode. Assumes reads have no side effects.
// Unmapped addresses and the clear address return zero.
module gpio_irq_rdmux
    import gpio_irq_pkg::*;
#(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [NUM_PINS-1:0] mode_q,
    input  logic [NUM_PINS-1:0] anyedg_q,
    input  logic [NUM_PINS-1:0] pol_q,
    input  logic [NUM_PINS-1:0] ena_q,
    input  logic [NUM_PINS-1:0] raw,
    input  logic [NUM_PINS-1:0] msk,
    output logic [NUM_PINS-1:0] bus_rdata
);
    // Purpose: choose the register that bus_addr names.
    always_comb begin
        bus_rdata = '0;
        if      (bus_addr == ADDR_W'(OFS_MODE))   bus_rdata = mode_q;
        else if (bus_addr == ADDR_W'(OFS_ANYEDG)) bus_rdata = anyedg_q;
        else if (bus_addr == ADDR_W'(OFS_POL))    bus_rdata = pol_q;
        else if (bus_addr == ADDR_W'(OFS_ENA))    bus_rdata = ena_q;
        else if (bus_addr == ADDR_W'(OFS_RAW))    bus_rdata = raw;
        else if (bus_addr == ADDR_W'(OFS_MSK))    bus_rdata = msk;
    end
endmodule

// File: rtl/gpio_irq_detect.sv
// Module: gpio_irq_detect
// Top of the interrupt detector. Assumes pin_i is synchronized to clk.
// Builds one detection lane per line and ANDs raw status with the enables.
// The OR of the masked bits drives the single interrupt request.
module gpio_irq_detect #(
    parameter int unsigned NUM_PINS = 8,
    parameter int unsigned ADDR_W   = 12
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic                bus_wr,
    input  logic [NUM_PINS-1:0] bus_wdata,
    output logic [NUM_PINS-1:0] bus_rdata,
    input  logic [NUM_PINS-1:0] pin_i,
    output logic                irq_o
);
    logic [NUM_PINS-1:0] mode_q;
    logic [NUM_PINS-1:0] anyedg_q;
    logic [NUM_PINS-1:0] pol_q;
    logic [NUM_PINS-1:0] ena_q;
    logic [NUM_PINS-1:0] clr_pulse;
    logic [NUM_PINS-1:0] raw;
    logic [NUM_PINS-1:0] msk;

    gpio_irq_cfg #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_cfg (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .mode_q(mode_q), .anyedg_q(anyedg_q),
        .pol_q(pol_q), .ena_q(ena_q), .clr_pulse(clr_pulse)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_lane
        gpio_irq_lane u_lane (
            .clk(clk), .rst_n(rst_n), .pin_i(pin_i[i]), .mode_i(mode_q[i]),
            .anyedg_i(anyedg_q[i]), .pol_i(pol_q[i]), .clr_i(clr_pulse[i]),
            .raw_o(raw[i])
        );
    end

    // Purpose: apply the enables and combine into one request.
    always_comb begin
        msk   = raw & ena_q;
        irq_o = |msk;
    end

    gpio_irq_rdmux #(.NUM_PINS(NUM_PINS), .ADDR_W(ADDR_W)) u_rd (
        .bus_addr(bus_addr), .mode_q(mode_q), .anyedg_q(anyedg_q),
        .pol_q(pol_q), .ena_q(ena_q), .raw(raw), .msk(msk),
        .bus_rdata(bus_rdata)
    );

    // R9: the request can only be high while some line is enabled
    a_r9_irq_needs_enable: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> (ena_q != '0));
endmodule

// File: tb/gpio_irq_detect_tb.sv
module gpio_irq_detect_tb;
    localparam int CLK_P = 10;
    localparam logic [11:0] A_MODE = 12'h404, A_ANY = 12'h408, A_POL = 12'h40C,
                            A_ENA = 12'h410, A_RAW = 12'h414, A_MSK = 12'h418,
                            A_CLR = 12'h41C;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [11:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  bus_rdata;
    logic [7:0]  pin_i = '0;
    logic        irq_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 0;

    // behavioural model state
    bit [7:0] m_mode, m_any, m_pol, m_ena, m_flag, m_prev;

    always #(CLK_P/2) clk = ~clk;

    gpio_irq_detect u_dut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_i(pin_i), .irq_o(irq_o)
    );

    function automatic bit [7:0] m_raw(input bit [7:0] p);
        bit [7:0] r;
        for (int i = 0; i < 8; i++)
            r[i] = m_mode[i] ? (p[i] == m_pol[i]) : m_flag[i];
        return r;
    endfunction

    function automatic bit [7:0] m_read(input bit [11:0] a, input bit [7:0] p);
        case (a)
            A_MODE:  return m_mode;
            A_ANY:   return m_any;
            A_POL:   return m_pol;
            A_ENA:   return m_ena;
            A_RAW:   return m_raw(p);
            A_MSK:   return m_raw(p) & m_ena;
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(input string tag, input string what, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
        end
    endtask

    // one cycle: drive, compare combinational outputs, advance the model
    task automatic step(input bit [7:0] p, input bit w, input bit [11:0] a,
                        input bit [7:0] d, input string tag);
        bit [7:0] clr, nflag;
        pin_i = p; bus_wr = w; bus_addr = a; bus_wdata = d;
        #2;
        check(tag, "rdata", bus_rdata, m_read(a, p));
        check(tag, "irq", irq_o, |(m_raw(p) & m_ena));
        clr = (w && a == A_CLR) ? d : 8'h00;
        for (int i = 0; i < 8; i++) begin
            bit r, f, hit;
            r = p[i] & ~m_prev[i];
            f = ~p[i] & m_prev[i];
            hit = m_any[i] ? (r | f) : (m_pol[i] ? r : f);
            nflag[i] = m_mode[i] ? 1'b0 : (hit | (m_flag[i] & ~clr[i]));
        end
        @(posedge clk);
        #1;
        m_flag = nflag;
        m_prev = p;
        if (w) begin
            if (a == A_MODE) m_mode = d;
            if (a == A_ANY)  m_any  = d;
            if (a == A_POL)  m_pol  = d;
            if (a == A_ENA)  m_ena  = d;
        end
    endtask

    initial begin
        #(CLK_P * 200000);
        if (!done) begin
            n_bad++; n_chk++;
            $display("FAIL watchdog: actual timeout expected finish");
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
            $finish;
        end
    end

    initial begin
        bit [7:0] pins;
        m_mode = 0; m_any = 0; m_pol = 0; m_ena = 0; m_flag = 0; m_prev = 0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1, R2: reset values at every address
        step(8'h00, 0, A_MODE, 0, "R1"); step(8'h00, 0, A_ANY, 0, "R1");
        step(8'h00, 0, A_POL, 0, "R1");  step(8'h00, 0, A_ENA, 0, "R1");
        step(8'h00, 0, A_RAW, 0, "R1");  step(8'h00, 0, A_MSK, 0, "R1");
        step(8'h00, 0, A_CLR, 0, "R2");  step(8'h00, 0, 12'h000, 0, "R2");
        // R2: writes read back
        step(8'h00, 1, A_ENA, 8'hFF, "R2"); step(8'h00, 0, A_ENA, 0, "R2");
        // R3: line0 active-high level, line4 active-low level
        step(8'h00, 1, A_POL, 8'h01, "R3");
        step(8'h00, 1, A_MODE, 8'h11, "R3");
        step(8'h00, 0, A_RAW, 0, "R3");
        step(8'h01, 0, A_RAW, 0, "R3");
        step(8'h11, 0, A_MSK, 0, "R3");
        step(8'h10, 0, A_RAW, 0, "R3");
        step(8'h00, 0, A_RAW, 0, "R3");
        step(8'h00, 1, A_MODE, 8'h00, "R3");
        // R4: line1 rising, line2 falling
        step(8'h04, 1, A_POL, 8'h02, "R4");
        step(8'h04, 1, A_CLR, 8'hFF, "R4");
        step(8'h04, 0, A_RAW, 0, "R4");
        step(8'h02, 0, A_RAW, 0, "R4");
        step(8'h02, 0, A_RAW, 0, "R4");
        // R5: sticky after the pins return
        step(8'h04, 0, A_RAW, 0, "R5");
        step(8'h04, 0, A_MSK, 0, "R5");
        // R7: clear with zeros does nothing, then clear line1 only
        step(8'h04, 1, A_CLR, 8'h00, "R7");
        step(8'h04, 1, A_CLR, 8'h02, "R7");
        step(8'h04, 0, A_RAW, 0, "R7");
        step(8'h04, 1, A_CLR, 8'h04, "R7");
        step(8'h04, 0, A_RAW, 0, "R7");
        // R6: line3 any-edge with polarity 0
        step(8'h04, 1, A_ANY, 8'h08, "R6");
        step(8'h0C, 0, A_RAW, 0, "R6");
        step(8'h0C, 1, A_CLR, 8'h08, "R6");
        step(8'h04, 0, A_RAW, 0, "R6");
        step(8'h04, 0, A_RAW, 0, "R6");
        step(8'h04, 1, A_CLR, 8'hFF, "R6");
        // R8: rising edge on line1 with a clear in the same cycle
        step(8'h06, 1, A_CLR, 8'h02, "R8");
        step(8'h06, 0, A_RAW, 0, "R8");
        // R7: clear on a level line leaves its status
        step(8'h06, 1, A_MODE, 8'h01, "R7");
        step(8'h07, 1, A_CLR, 8'h01, "R7");
        step(8'h07, 0, A_RAW, 0, "R7");
        // R10: writes to status and unmapped addresses ignored
        step(8'h07, 1, A_RAW, 8'h00, "R10");
        step(8'h07, 1, A_MSK, 8'h00, "R10");
        step(8'h07, 1, 12'h123, 8'h55, "R10");
        step(8'h07, 0, A_MODE, 0, "R10");
        step(8'h07, 0, A_ENA, 0, "R10");
        step(8'h07, 0, A_RAW, 0, "R10");
        // R11: line1 flag set, go to level, return to edge: no event pending
        step(8'h07, 1, A_MODE, 8'h03, "R11");
        step(8'h07, 1, A_POL, 8'h00, "R11");
        step(8'h07, 1, A_MODE, 8'h01, "R11");
        step(8'h07, 0, A_RAW, 0, "R11");
        // R9: masking removes the request
        step(8'h07, 1, A_ENA, 8'h00, "R9");
        step(8'h07, 0, A_MSK, 0, "R9");
        step(8'h07, 1, A_ENA, 8'h01, "R9");
        step(8'h06, 0, A_MSK, 0, "R9");
        // random mix against the model
        for (int k = 0; k < 2000; k++) begin
            bit [11:0] a;
            bit w;
            case ($urandom_range(0, 8))
                0: a = A_MODE; 1: a = A_ANY; 2: a = A_POL; 3: a = A_ENA;
                4: a = A_RAW;  5: a = A_MSK; 6, 7: a = A_CLR; default: a = 12'h7F0;
            endcase
            w = ($urandom_range(0, 3) == 0);
            pins = ($urandom_range(0, 1) == 0) ? pin_i : 8'($urandom);
            step(pins, w, a, 8'($urandom), "R9");
        end
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        $finish;
    end
endmodule